// File: doc/BRIEF.md
# Synchronous Burst-Write Host Bus Slave

This block is the write side of a synchronous host-bus slave. Address and data travel on separate buses, and every data word comes with its own address, so a burst can scatter its words anywhere. The host opens a burst by pulling both the chip select and the data strobe low with the read/write select low. After a programmable number of wait cycles the slave drives its active-low ready output low. From then on it takes one address/data pair on each rising clock edge while ready is low. The host marks the final word by pulling an active-low last flag low. The slave takes that word on the next edge and raises ready on the same edge.

Each accepted word is presented for one cycle on a registered write port. A space select bit, sampled with the word, routes it to a memory strobe or to a register strobe. The same word is also pushed into a small command queue that a downstream consumer drains. When that queue is full, the active-low stop output goes low and ready is held high, which stalls the burst without losing words. A word whose 16-bit lane enable is not both-lanes-on is thrown away, and a sticky error flag is set. If the host lets go of the chip select or the strobe in the middle of a burst, the burst is cut short.

Top module: `hbw_slave`

## Requirements
- R1: While reset is high and on the first cycle after it, host_rdy_n and host_stop_n are 1, mem_we, reg_we, err and cmd_valid are 0.
- R2: A burst starts only when host_sel_n and host_strb_n are both 0 and host_rd is 0 at a rising edge in idle; host_rdy_n then first reads 0 after WAIT_CYC further rising edges, one cycle before the first word is taken. With host_rd at 1, host_rdy_n stays 1.
- R3: At each rising edge where host_rdy_n is 0 and host_wen is 2'b11, the pair on host_addr/host_data is taken as given (no address increment) and appears one cycle later on wr_addr/wr_data with mem_we=1 if host_space was 1, or reg_we=1 if it was 0, never both.
- R4: The word present at an edge where host_rdy_n and host_last_n are both 0 is the last one taken; host_rdy_n is 1 after that edge and stays 1 until host_sel_n or host_strb_n has gone high and a new burst starts.
- R5: A word taken with host_wen other than 2'b11 produces no write strobe and no queue entry, sets err to 1, and err then stays 1 until reset; the burst continues.
- R6: Every written word enters the command queue in order; while cmd_valid is 1, cmd_is_mem/cmd_addr/cmd_data show the oldest entry, and cmd_pop=1 at a rising edge removes it.
- R7: host_stop_n is 0 exactly while the queue holds FIFO_DEPTH entries; during that time host_rdy_n is 1 and no word is taken, and the burst resumes once an entry is popped.
- R8: If host_sel_n or host_strb_n is 1 at an edge during a burst, no word is taken at that edge, host_rdy_n is 1 after it, and the slave returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous reset, active high |
| host_sel_n | input | 1 | Chip select, active low |
| host_strb_n | input | 1 | Data strobe, active low |
| host_addr | input | 16 | Word address, one per beat |
| host_space | input | 1 | 1 = memory target, 0 = register target |
| host_rd | input | 1 | Read/write select, must be 0 for a write burst |
| host_wen | input | 2 | Byte lane enables, 2'b11 for a 16-bit word |
| host_last_n | input | 1 | Final-word flag, active low |
| host_data | input | 16 | Write data |
| host_rdy_n | output | 1 | Data-ready handshake, active low |
| host_stop_n | output | 1 | Queue-full backpressure, active low |
| mem_we | output | 1 | Memory write strobe |
| reg_we | output | 1 | Register write strobe |
| wr_addr | output | 16 | Write-port address |
| wr_data | output | 16 | Write-port data |
| err | output | 1 | Sticky bad-lane-enable flag |
| cmd_valid | output | 1 | Command queue not empty |
| cmd_pop | input | 1 | Remove the oldest queue entry |
| cmd_is_mem | output | 1 | Space bit of the oldest entry |
| cmd_addr | output | 16 | Address of the oldest entry |
| cmd_data | output | 16 | Data of the oldest entry |

## Verification
Some rules are local and the assertions check them on every cycle. They are that a write strobe follows a qualified sample edge with the sampled address, that the two strobes are exclusive, and that ready rises after a last-flagged or aborted edge. They also check that err never falls back to 0 and that a full queue holds ready high and blocks any write on the next cycle. Other behaviour needs whole scenarios, and only the bench shows it. That covers the exact wait-cycle count before ready, the refusal to restart while select is still held after the last word, and read-select bursts being ignored. It also covers the order and content of words leaving the queue, and a burst that stalls on a full queue and resumes with every word intact.

// File: rtl/hbw_pkg.sv
package hbw_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int WEN_W  = 2;
    localparam logic [WEN_W-1:0] WEN_WORD = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_XFER = 2'd2,
        ST_HOLD = 2'd3
    } hbw_state_e;

    typedef struct packed {
        logic              is_mem;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } hbw_beat_t;

    function automatic logic bus_active(input logic sel_n, input logic strb_n);
        return !sel_n && !strb_n;
    endfunction

    function automatic logic lanes_full(input logic [WEN_W-1:0] wen);
        return wen == WEN_WORD;
    endfunction

endpackage

// File: rtl/hbw_ctrl.sv
module hbw_ctrl
    import hbw_pkg::*;
#(
    parameter int WAIT_CYC = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_n,
    input  logic             strb_n,
    input  logic             rd,
    input  logic [WEN_W-1:0] wen,
    input  logic             last_n,
    input  logic             q_full,
    output logic             rdy_n,
    output logic             take,
    output logic             err
);

    localparam int CW = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;

    hbw_state_e     state;
    logic [CW-1:0]  wcnt;
    logic           active;
    logic           sample;

    assign active = bus_active(sel_n, strb_n);
    assign sample = (state == ST_XFER) && !q_full && active;
    assign take   = sample && lanes_full(wen);
    assign rdy_n  = !((state == ST_XFER) && !q_full);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            wcnt  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (active && !rd) begin
                        state <= ST_WAIT;
                        wcnt  <= CW'(WAIT_CYC - 1);
                    end
                end
                ST_WAIT: begin
                    if (!active) begin
                        state <= ST_IDLE;
                    end else if (wcnt == '0) begin
                        state <= ST_XFER;
                    end else begin
                        wcnt <= wcnt - 1'b1;
                    end
                end
                ST_XFER: begin
                    if (!active) begin
                        state <= ST_IDLE;
                    end else if (sample && !last_n) begin
                        state <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (!active) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err <= 1'b0;
        end else if (sample && !lanes_full(wen)) begin
            err <= 1'b1;
        end
    end

endmodule

// File: rtl/hbw_fifo.sv
module hbw_fifo
    import hbw_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  hbw_beat_t din,
    input  logic      pop,
    output hbw_beat_t dout,
    output logic      full,
    output logic      empty
);

    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    hbw_beat_t       mem [DEPTH];
    logic [PW-1:0]   wr_ptr;
    logic [PW-1:0]   rd_ptr;
    logic [CNTW-1:0] count;
    logic            do_push;
    logic            do_pop;

    assign full    = (count == CNTW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/hbw_wport.sv
module hbw_wport
    import hbw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  hbw_beat_t         beat,
    output logic              mem_we,
    output logic              reg_we,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    logic [1:0] strobe;

    for (genvar t = 0; t < 2; t++) begin : g_tgt
        always_ff @(posedge clk) begin
            if (rst) begin
                strobe[t] <= 1'b0;
            end else begin
                strobe[t] <= take && (beat.is_mem == logic'(t));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_addr <= '0;
            wr_data <= '0;
        end else if (take) begin
            wr_addr <= beat.addr;
            wr_data <= beat.data;
        end
    end

    assign reg_we = strobe[0];
    assign mem_we = strobe[1];

endmodule

// File: rtl/hbw_slave.sv
module hbw_slave
    import hbw_pkg::*;
#(
    parameter int WAIT_CYC   = 1,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_sel_n,
    input  logic              host_strb_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_space,
    input  logic              host_rd,
    input  logic [WEN_W-1:0]  host_wen,
    input  logic              host_last_n,
    input  logic [DATA_W-1:0] host_data,
    output logic              host_rdy_n,
    output logic              host_stop_n,
    output logic              mem_we,
    output logic              reg_we,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              err,
    output logic              cmd_valid,
    input  logic              cmd_pop,
    output logic              cmd_is_mem,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data
);

    hbw_beat_t in_beat;
    hbw_beat_t head;
    logic      take;
    logic      q_full;
    logic      q_empty;

    assign in_beat = '{is_mem: host_space, addr: host_addr, data: host_data};

    hbw_ctrl #(.WAIT_CYC(WAIT_CYC)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .sel_n  (host_sel_n),
        .strb_n (host_strb_n),
        .rd     (host_rd),
        .wen    (host_wen),
        .last_n (host_last_n),
        .q_full (q_full),
        .rdy_n  (host_rdy_n),
        .take   (take),
        .err    (err)
    );

    hbw_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (take),
        .din   (in_beat),
        .pop   (cmd_pop),
        .dout  (head),
        .full  (q_full),
        .empty (q_empty)
    );

    hbw_wport u_wport (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .beat    (in_beat),
        .mem_we  (mem_we),
        .reg_we  (reg_we),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    assign host_stop_n = !q_full;
    assign cmd_valid   = !q_empty;
    assign cmd_is_mem  = head.is_mem;
    assign cmd_addr    = head.addr;
    assign cmd_data    = head.data;

endmodule

// File: rtl/hbw_chk.sv
module hbw_chk
    import hbw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              host_sel_n,
    input logic              host_strb_n,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_space,
    input logic [WEN_W-1:0]  host_wen,
    input logic              host_last_n,
    input logic              host_rdy_n,
    input logic              host_stop_n,
    input logic              mem_we,
    input logic              reg_we,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              err,
    input logic              cmd_valid
);

    logic edge_live;
    assign edge_live = !host_rdy_n && !host_sel_n && !host_strb_n;

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && reg_we));

    // R3
    write_source_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we || reg_we) |-> ($past(edge_live) && $past(host_wen) == WEN_WORD
                                && wr_addr == $past(host_addr)
                                && mem_we == $past(host_space)));

    // R4
    last_release_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_live && !host_last_n) |=> host_rdy_n);

    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R5
    bad_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_live && host_wen != WEN_WORD) |=> (err && !mem_we && !reg_we));

    // R7
    full_holds_rdy_chk: assert property (@(posedge clk) disable iff (rst)
        !host_stop_n |-> (host_rdy_n && cmd_valid));

    // R7
    full_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        !host_stop_n |=> (!mem_we && !reg_we));

    // R8
    abort_chk: assert property (@(posedge clk) disable iff (rst)
        (!host_rdy_n && (host_sel_n || host_strb_n)) |=> (host_rdy_n && !mem_we && !reg_we));

endmodule

bind hbw_slave hbw_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_sel_n  (host_sel_n),
    .host_strb_n (host_strb_n),
    .host_addr   (host_addr),
    .host_space  (host_space),
    .host_wen    (host_wen),
    .host_last_n (host_last_n),
    .host_rdy_n  (host_rdy_n),
    .host_stop_n (host_stop_n),
    .mem_we      (mem_we),
    .reg_we      (reg_we),
    .wr_addr     (wr_addr),
    .err         (err),
    .cmd_valid   (cmd_valid)
);

// File: tb/tb_hbw_slave.sv
`timescale 1ns/1ps
module tb_hbw_slave;
    import hbw_pkg::*;

    localparam int WAIT_CYC = 1;
    localparam int DEPTH    = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              host_sel_n = 1'b1, host_strb_n = 1'b1;
    logic [ADDR_W-1:0] host_addr = '0;
    logic              host_space = 1'b0, host_rd = 1'b0;
    logic [WEN_W-1:0]  host_wen = 2'b11;
    logic              host_last_n = 1'b1;
    logic [DATA_W-1:0] host_data = '0;
    logic              host_rdy_n, host_stop_n, mem_we, reg_we, err, cmd_valid;
    logic              cmd_pop = 1'b0, cmd_is_mem;
    logic [ADDR_W-1:0] wr_addr, cmd_addr;
    logic [DATA_W-1:0] wr_data, cmd_data;

    hbw_slave #(.WAIT_CYC(WAIT_CYC), .FIFO_DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .host_sel_n(host_sel_n), .host_strb_n(host_strb_n),
        .host_addr(host_addr), .host_space(host_space), .host_rd(host_rd),
        .host_wen(host_wen), .host_last_n(host_last_n), .host_data(host_data),
        .host_rdy_n(host_rdy_n), .host_stop_n(host_stop_n), .mem_we(mem_we),
        .reg_we(reg_we), .wr_addr(wr_addr), .wr_data(wr_data), .err(err),
        .cmd_valid(cmd_valid), .cmd_pop(cmd_pop), .cmd_is_mem(cmd_is_mem),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data)
    );

    always #2.5 clk = ~clk;

    int total = 0, bad = 0, wr_cnt = 0;
    hbw_beat_t wq[$];
    hbw_beat_t fq[$];
    hbw_beat_t b_beat [16];
    logic [1:0] b_wen [16];
    hbw_beat_t mon_e;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor for the write port (R3)
    always @(negedge clk) begin
        if (!rst && (mem_we || reg_we)) begin
            wr_cnt++;
            if (wq.size() == 0) begin
                chk(1'b0, "R3", "unexpected write", {mem_we, reg_we, wr_addr}, 0);
            end else begin
                mon_e = wq.pop_front();
                chk(mem_we == mon_e.is_mem && reg_we == !mon_e.is_mem &&
                    wr_addr == mon_e.addr && wr_data == mon_e.data, "R3", "write beat",
                    {mem_we, reg_we, wr_addr, wr_data},
                    {mon_e.is_mem, !mon_e.is_mem, mon_e.addr, mon_e.data});
            end
        end
    end

    task automatic fill(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            b_beat[i].is_mem = ((i + seed) % 3) != 0;
            b_beat[i].addr   = ADDR_W'((seed * 97 + i * 1531 + (i * i) * 37) & 16'hffff);
            b_beat[i].data   = DATA_W'((seed * 4099 + i * 257 + 16'h5a) & 16'hffff);
            b_wen[i]         = 2'b11;
        end
    endtask

    task automatic put_beat(input int i, input bit last);
        host_addr   = b_beat[i].addr;
        host_data   = b_beat[i].data;
        host_space  = b_beat[i].is_mem;
        host_wen    = b_wen[i];
        host_last_n = !last;
    endtask

    // Driver: presents beats, pushes expected items when a beat is accepted
    task automatic drive_beats(input int n, input bit mark_last, output int first_wait);
        int guard;
        first_wait = 0;
        for (int i = 0; i < n; i++) begin
            put_beat(i, mark_last && (i == n - 1));
            guard = 0;
            while (host_rdy_n && guard < 2000) begin
                @(negedge clk);
                guard++;
                if (i == 0) first_wait++;
            end
            if (guard >= 2000) chk(1'b0, "R7", "beat never accepted", i, 0);
            if (b_wen[i] == 2'b11) begin
                wq.push_back(b_beat[i]);
                fq.push_back(b_beat[i]);
            end
            @(negedge clk);
        end
    endtask

    task automatic run_burst(input int n, output int first_wait);
        host_rd = 1'b0; host_sel_n = 1'b0; host_strb_n = 1'b0;
        drive_beats(n, 1'b1, first_wait);
        chk(host_rdy_n == 1'b1, "R4", "ready after last beat", host_rdy_n, 1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(host_rdy_n == 1'b1, "R4", "ready while select held after last", host_rdy_n, 1);
        end
        host_sel_n = 1'b1; host_strb_n = 1'b1; host_last_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic drain();
        @(negedge clk);
        while (cmd_valid) begin
            if (fq.size() == 0) begin
                chk(1'b0, "R6", "unexpected queue entry", cmd_addr, 0);
            end else begin
                mon_e = fq.pop_front();
                chk(cmd_is_mem == mon_e.is_mem && cmd_addr == mon_e.addr &&
                    cmd_data == mon_e.data, "R6", "queue head",
                    {cmd_is_mem, cmd_addr, cmd_data}, {mon_e.is_mem, mon_e.addr, mon_e.data});
            end
            cmd_pop = 1'b1;
            @(negedge clk);
            cmd_pop = 1'b0;
        end
    endtask

    initial begin
        #(200000 * 5);
        chk(1'b0, "R1", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int w;
        int base;
        repeat (4) @(negedge clk);
        chk(host_rdy_n && host_stop_n && !mem_we && !reg_we && !err && !cmd_valid,
            "R1", "outputs in reset", {host_rdy_n, host_stop_n, mem_we, reg_we, err, cmd_valid}, 6'b110000);
        rst = 1'b0;
        @(negedge clk);
        chk(host_rdy_n && host_stop_n && !mem_we && !reg_we && !err && !cmd_valid,
            "R1", "outputs after reset", {host_rdy_n, host_stop_n, mem_we, reg_we, err, cmd_valid}, 6'b110000);

        // R2: read select blocks a burst
        host_rd = 1'b1; host_sel_n = 1'b0; host_strb_n = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(host_rdy_n == 1'b1, "R2", "ready with read select", host_rdy_n, 1);
        end
        host_sel_n = 1'b1; host_strb_n = 1'b1; host_rd = 1'b0;
        @(negedge clk);
        chk(wr_cnt == 0, "R2", "writes with read select", wr_cnt, 0);

        // R2, R3, R6: plain burst with scattered addresses
        fill(3, 1);
        run_burst(3, w);
        chk(w == WAIT_CYC + 1, "R2", "cycles until ready", w, WAIT_CYC + 1);
        drain();
        chk(fq.size() == 0 && wq.size() == 0, "R6", "all beats delivered", fq.size() + wq.size(), 0);

        // R5: bad lane enables discard beats, err sticks
        fill(4, 7);
        b_wen[1] = 2'b01;
        b_wen[3] = 2'b10;
        base = wr_cnt;
        run_burst(4, w);
        chk(err == 1'b1, "R5", "err after bad lanes", err, 1);
        chk(wr_cnt - base == 2, "R5", "writes with bad lanes", wr_cnt - base, 2);
        drain();
        fill(2, 11);
        run_burst(2, w);
        chk(err == 1'b1, "R5", "err stays set", err, 1);
        drain();

        // R8: abort mid-burst
        fill(3, 21);
        base = wr_cnt;
        host_rd = 1'b0; host_sel_n = 1'b0; host_strb_n = 1'b0;
        drive_beats(2, 1'b0, w);
        chk(host_rdy_n == 1'b0, "R8", "ready before abort", host_rdy_n, 0);
        put_beat(2, 1'b0);
        host_sel_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(host_rdy_n == 1'b1, "R8", "ready after abort", host_rdy_n, 1);
        end
        chk(wr_cnt - base == 2, "R8", "writes after abort", wr_cnt - base, 2);
        host_strb_n = 1'b1;
        drain();

        // R7: full queue stalls the burst
        fill(6, 33);
        base = wr_cnt;
        fork
            run_burst(6, w);
            begin
                int g;
                g = 0;
                while (host_stop_n && g < 200) begin
                    @(negedge clk);
                    g++;
                end
                repeat (3) @(negedge clk);
                for (int k = 0; k < 3; k++) begin
                    chk(host_stop_n == 1'b0, "R7", "stop while full", host_stop_n, 0);
                    chk(host_rdy_n == 1'b1, "R7", "ready while full", host_rdy_n, 1);
                    @(negedge clk);
                end
                chk(wr_cnt - base == DEPTH, "R7", "writes before stall release", wr_cnt - base, DEPTH);
                drain();
            end
        join
        drain();
        chk(wr_cnt - base == 6, "R7", "writes after resume", wr_cnt - base, 6);
        chk(host_stop_n == 1'b1, "R7", "stop after drain", host_stop_n, 1);
        chk(wq.size() == 0 && fq.size() == 0, "R6", "scoreboard empty", wq.size() + fq.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule